// File: doc/BRIEF.md
# Cycle-Bit Transfer Ring Consumer

This block reads 16-byte transfer request entries from a ring in memory and streams them out. The ring is reached through a simple synchronous read port: a read request in one cycle returns its entry in the next. A doorbell pulse wakes the consumer. From then on it fetches at its dequeue pointer. It keeps consuming as long as the cycle bit of each fetched entry equals its own consumer cycle state. At the first entry whose cycle bit differs, it stops and waits for another doorbell.

The ring may be split into several segments. The last slot of a segment holds a link entry. A link entry sends the dequeue pointer to the start of another segment and may invert the consumer cycle state on the way. Over one full lap of the ring the state must be inverted an odd number of times. Link entries are used internally and never appear on the output.

Every other entry is passed out with two markers. A start marker flags the first entry of a transfer descriptor. An end marker flags an entry whose chain bit is clear, which closes the descriptor. A descriptor may span several doorbells.

Top module: `trb_ring_consumer`

## Requirements
- R1: While reset is held and after it is released, no read is requested and no entry is output until a doorbell arrives. The consumer cycle state starts at 1, and the first read after reset is at the parameter `BASE_ADDR`.
- R2: An entry is 128 bits wide, and the dequeue pointer steps by 16 bytes per consumed entry. The field positions are: cycle bit at bit 96, toggle flag at bit 97, chain bit at bit 100, and entry type at bits [111:106]. Type value 6 marks a link entry. A link's target byte address is in bits [AW-1:0], and its low 4 bits are ignored. A consumed entry is output with all 128 bits unchanged.
- R3: An entry is consumed only when its cycle bit equals the consumer cycle state. At a mismatching entry nothing is output, the pointer holds, and no further read is issued until the next doorbell.
- R4: A doorbell sampled in cycle t issues a read in cycle t+1. A consumed entry appears on the output two cycles after its read request. Back-to-back entries within a segment appear every 2 cycles.
- R5: A link entry moves the dequeue pointer to its target and is never output. Following it adds 2 cycles before the next output.
- R6: A link with the toggle flag set inverts the consumer cycle state. A link with the flag clear leaves the state unchanged.
- R7: The start marker is set on the first entry output after reset and on every entry output after an entry with a clear chain bit. It is clear otherwise.
- R8: The end marker equals the inverse of the output entry's chain bit.
- R9: A doorbell that arrives while the consumer is busy is remembered. This includes the cycle in which a mismatching entry is returned. The consumer then re-reads the same slot instead of going idle.
- R10: Read addresses are always 16-byte aligned, and a read request is never asserted in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| doorbell | input | 1 | One-cycle pulse: new entries may have been enqueued |
| mem_rd_en | output | 1 | Read request to the ring memory |
| mem_rd_addr | output | AW | Byte address of the requested entry |
| mem_rd_data | input | 128 | Entry returned one cycle after the request |
| out_valid | output | 1 | A consumed entry is presented this cycle |
| out_entry | output | 128 | The consumed entry |
| out_sod | output | 1 | Entry opens a transfer descriptor |
| out_eod | output | 1 | Entry closes a transfer descriptor |

## Verification
A doorbell sampled at an edge produces a read in the following cycle, and the entry appears on the output two edges after that read. Each further entry follows 2 cycles later, plus 2 cycles for every link followed in between. The bench stamps each output with a cycle count. It derives the due cycle of every expected entry from these delays and compares the gaps between entries against them, sampling on the falling edge so that every register stage has settled. After each batch the bench waits past the last due cycle and checks that no read or output follows.

// File: rtl/trb_ring_pkg.sv
package trb_ring_pkg;
  localparam int ENTRY_W    = 128;
  localparam int OFS_W      = 4;
  localparam int CYC_BIT    = 96;
  localparam int TGL_BIT    = 97;
  localparam int CHN_BIT    = 100;
  localparam int TYPE_LO    = 106;
  localparam int TYPE_W     = 6;
  localparam logic [TYPE_W-1:0] TYPE_LINK = 6'd6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } fsm_e;
endpackage

// File: rtl/trb_field_decode.sv
module trb_field_decode
  import trb_ring_pkg::*;
(
  input  logic              cyc_bit,
  input  logic              tgl_bit,
  input  logic              chn_bit,
  input  logic [TYPE_W-1:0] type_f,
  input  logic              ccs,
  output logic              owned,
  output logic              is_link,
  output logic              chained,
  output logic              toggle
);
  always_comb begin
    owned   = (cyc_bit == ccs);
    is_link = (type_f == TYPE_LINK);
    chained = chn_bit;
    toggle  = tgl_bit;
  end
endmodule

// File: rtl/trb_deq_state.sv
module trb_deq_state #(
  parameter int              PW      = 12,
  parameter logic [PW-1:0]   RST_PTR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic          link_en,
  input  logic          tgl,
  input  logic [PW-1:0] tgt,
  output logic [PW-1:0] ptr_q,
  output logic          ccs_q
);
  logic [PW-1:0] ptr_d;
  logic          ccs_d;

  always_comb begin
    ptr_d = ptr_q;
    ccs_d = ccs_q;
    if (link_en) begin
      ptr_d = tgt;
      ccs_d = ccs_q ^ tgl;
    end else if (adv_en) begin
      ptr_d = ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= RST_PTR;
      ccs_q <= 1'b1;
    end else if (adv_en || link_en) begin
      ptr_q <= ptr_d;
      ccs_q <= ccs_d;
    end
  end
endmodule

// File: rtl/trb_td_marker.sv
module trb_td_marker
  import trb_ring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [ENTRY_W-1:0] entry_in,
  input  logic               chained,
  output logic               out_valid,
  output logic [ENTRY_W-1:0] out_entry,
  output logic               out_sod,
  output logic               out_eod
);
  logic open_q, open_d;
  logic sod_d, eod_d;

  always_comb begin
    sod_d  = !open_q;
    eod_d  = !chained;
    open_d = take ? chained : open_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      open_q    <= 1'b0;
    end else begin
      out_valid <= take;
      open_q    <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_entry <= '0;
      out_sod   <= 1'b0;
      out_eod   <= 1'b0;
    end else if (take) begin
      out_entry <= entry_in;
      out_sod   <= sod_d;
      out_eod   <= eod_d;
    end
  end
endmodule

// File: rtl/trb_ring_consumer.sv
module trb_ring_consumer
  import trb_ring_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] BASE_ADDR = 16'h0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               doorbell,
  output logic               mem_rd_en,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic [ENTRY_W-1:0] mem_rd_data,
  output logic               out_valid,
  output logic [ENTRY_W-1:0] out_entry,
  output logic               out_sod,
  output logic               out_eod
);
  localparam int PW = AW - OFS_W;
  localparam logic [PW-1:0] RST_PTR = BASE_ADDR[AW-1:OFS_W];

  fsm_e          st_q, st_d;
  logic          pend_q, pend_d;
  logic [PW-1:0] ptr_q;
  logic          ccs_q;
  logic          owned, is_link, chained, toggle;
  logic          take, follow, stall;

  trb_field_decode u_dec (
    .cyc_bit (mem_rd_data[CYC_BIT]),
    .tgl_bit (mem_rd_data[TGL_BIT]),
    .chn_bit (mem_rd_data[CHN_BIT]),
    .type_f  (mem_rd_data[TYPE_LO +: TYPE_W]),
    .ccs     (ccs_q),
    .owned   (owned),
    .is_link (is_link),
    .chained (chained),
    .toggle  (toggle)
  );

  always_comb begin
    take   = (st_q == ST_WAIT) && owned && !is_link;
    follow = (st_q == ST_WAIT) && owned && is_link;
    stall  = (st_q == ST_WAIT) && !owned;
  end

  trb_deq_state #(.PW(PW), .RST_PTR(RST_PTR)) u_deq (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_en  (take),
    .link_en (follow),
    .tgl     (toggle),
    .tgt     (mem_rd_data[AW-1:OFS_W]),
    .ptr_q   (ptr_q),
    .ccs_q   (ccs_q)
  );

  trb_td_marker u_mark (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .entry_in  (mem_rd_data),
    .chained   (chained),
    .out_valid (out_valid),
    .out_entry (out_entry),
    .out_sod   (out_sod),
    .out_eod   (out_eod)
  );

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    case (st_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (doorbell) st_d = ST_FETCH;
      end
      ST_FETCH: begin
        pend_d = pend_q | doorbell;
        st_d   = ST_WAIT;
      end
      ST_WAIT: begin
        if (stall) begin
          pend_d = 1'b0;
          st_d   = (pend_q || doorbell) ? ST_FETCH : ST_IDLE;
        end else begin
          pend_d = pend_q | doorbell;
          st_d   = ST_FETCH;
        end
      end
      default: begin
        pend_d = 1'b0;
        st_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign mem_rd_en   = (st_q == ST_FETCH);
  assign mem_rd_addr = {ptr_q, {OFS_W{1'b0}}};
endmodule

// File: rtl/trb_ring_consumer_chk.sv
module trb_ring_consumer_chk
  import trb_ring_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_en,
  input logic [OFS_W-1:0]  rd_addr_lo,
  input logic              out_valid,
  input logic              out_sod,
  input logic              out_eod,
  input logic [TYPE_W-1:0] out_type,
  input logic              out_chain
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (out_valid) open_q <= !out_eod;
  end

  // R10
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R10
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (rd_addr_lo == '0));

  // R4
  emit_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mem_rd_en, 2));

  // R5
  no_link_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_type != TYPE_LINK));

  // R7
  sod_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sod == !open_q));

  // R8
  eod_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_eod == !out_chain));
endmodule

bind trb_ring_consumer trb_ring_consumer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd_en  (mem_rd_en),
  .rd_addr_lo (mem_rd_addr[trb_ring_pkg::OFS_W-1:0]),
  .out_valid  (out_valid),
  .out_sod    (out_sod),
  .out_eod    (out_eod),
  .out_type   (out_entry[trb_ring_pkg::TYPE_LO +: trb_ring_pkg::TYPE_W]),
  .out_chain  (out_entry[trb_ring_pkg::CHN_BIT])
);

// File: tb/trb_ring_consumer_bench.sv
module trb_ring_consumer_bench;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0100;
  localparam int SEG_A = 'h100, LINK_A = 'h170, SEG_B = 'h300, LINK_B = 'h370;

  logic clk = 1'b0;
  logic rst_n, doorbell;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [127:0] mem_rd_data;
  logic out_valid, out_sod, out_eod;
  logic [127:0] out_entry;

  always #4 clk = ~clk;

  trb_ring_consumer #(.AW(AW), .BASE_ADDR(BASE)) u_trb_ring_consumer (
    .clk(clk), .rst_n(rst_n), .doorbell(doorbell),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_entry(out_entry), .out_sod(out_sod), .out_eod(out_eod)
  );

  logic [127:0] mem [64];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:4]];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [127:0] got_e[$];
  bit got_s[$], got_d[$];
  int got_t[$];
  int rd_count = 0;
  int first_addr = -1;
  bit prev_rd = 0, rd_back2back = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got_e.push_back(out_entry); got_s.push_back(out_sod);
      got_d.push_back(out_eod); got_t.push_back(cyc);
    end
    if (rst_n && mem_rd_en) begin
      rd_count++;
      if (first_addr < 0) first_addr = int'(mem_rd_addr);
      if (prev_rd) rd_back2back = 1;
    end
    prev_rd = rst_n && mem_rd_en;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_entry(input int tag, input bit chain, input bit c);
    logic [127:0] e = '0;
    e[31:0] = tag;
    e[111:106] = 6'd1;
    e[100] = chain;
    e[96] = c;
    return e;
  endfunction

  function automatic logic [127:0] mk_link(input int tgt, input bit tgl, input bit c);
    logic [127:0] e = '0;
    e[15:0] = tgt[15:0];
    e[111:106] = 6'd6;
    e[97] = tgl;
    e[96] = c;
    return e;
  endfunction

  // producer side
  int p_ptr = SEG_A;
  bit p_cs = 1;
  task automatic enqueue(input int tag, input bit chain);
    mem[p_ptr >> 4] = mk_entry(tag, chain, p_cs);
    p_ptr += 16;
    if (p_ptr == LINK_A) begin
      mem[p_ptr >> 4] = mk_link(SEG_B, 1'b0, p_cs);
      p_ptr = SEG_B;
    end else if (p_ptr == LINK_B) begin
      mem[p_ptr >> 4] = mk_link(SEG_A, 1'b1, p_cs);
      p_ptr = SEG_A;
      p_cs = ~p_cs;
    end
  endtask

  // expected consumer behaviour derived from the requirements
  int m_ptr = int'(BASE);
  bit m_ccs = 1, m_open = 0;
  logic [127:0] exp_e[$];
  bit exp_s[$], exp_d[$];
  int exp_gap[$], exp_lnk[$];
  task automatic run_model();
    int links = 0;
    forever begin
      logic [127:0] e = mem[(m_ptr >> 4) & 63];
      if (e[96] != m_ccs) break;
      if (e[111:106] == 6'd6) begin
        m_ptr = int'(e[15:0]) & 'hFFF0;
        if (e[97]) m_ccs = ~m_ccs;
        links++;
      end else begin
        exp_e.push_back(e); exp_s.push_back(!m_open); exp_d.push_back(!e[100]);
        exp_gap.push_back(2 + 2 * links); exp_lnk.push_back(links);
        m_open = e[100];
        m_ptr += 16;
        links = 0;
      end
    end
  endtask

  int t_db;
  task automatic ring();
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
    t_db = cyc;
  endtask

  task automatic compare_batch(input string tag);
    int prev;
    chk(got_e.size() == exp_e.size(), "R3 R6", {tag, " entry count"},
        128'(got_e.size()), 128'(exp_e.size()));
    prev = t_db;
    for (int i = 0; i < exp_e.size() && i < got_e.size(); i++) begin
      chk(got_e[i] == exp_e[i], "R2", {tag, " entry"}, got_e[i], exp_e[i]);
      chk(got_s[i] == exp_s[i], "R7", {tag, " start marker"}, 128'(got_s[i]), 128'(exp_s[i]));
      chk(got_d[i] == exp_d[i], "R8", {tag, " end marker"}, 128'(got_d[i]), 128'(exp_d[i]));
      chk(got_t[i] - prev == exp_gap[i], exp_lnk[i] != 0 ? "R5" : "R4",
          {tag, " output timing"}, 128'(got_t[i] - prev), 128'(exp_gap[i]));
      prev = got_t[i];
    end
    got_e.delete(); got_s.delete(); got_d.delete(); got_t.delete();
    exp_e.delete(); exp_s.delete(); exp_d.delete(); exp_gap.delete(); exp_lnk.delete();
  endtask

  initial begin
    int rc;
    doorbell = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!mem_rd_en && !out_valid, "R1", "outputs in reset",
        {126'b0, mem_rd_en, out_valid}, 128'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(rd_count == 0 && got_e.size() == 0, "R1", "quiet without doorbell",
        128'(rd_count), 128'b0);

    // sweep of batch sizes and chain patterns across many laps
    for (int r = 0; r < 40; r++) begin
      int n = (r * 5) % 11 + 1;
      for (int i = 0; i < n; i++)
        enqueue(r * 16 + i, ((r * 7 + i * 3) % 5) < 2);
      run_model();
      ring();
      repeat (2 * n + 16) @(negedge clk);
      if (r == 0)
        chk(first_addr == int'(BASE), "R1", "first read address",
            128'(first_addr), 128'(BASE));
      compare_batch($sformatf("round %0d", r));
      rc = rd_count;
      repeat (12) @(negedge clk);
      chk(rd_count == rc && got_e.size() == 0, "R3", "idle after stall",
          128'(rd_count - rc), 128'b0);
    end

    // doorbell during the read of a stale slot
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
    @(negedge clk);
    enqueue(16'hBEEF, 1'b0);
    doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
    run_model();
    repeat (16) @(negedge clk);
    chk(got_e.size() == 1 && exp_e.size() == 1, "R9", "remembered doorbell",
        128'(got_e.size()), 128'(1));
    if (got_e.size() == 1 && exp_e.size() == 1)
      chk(got_e[0] == exp_e[0], "R9", "remembered doorbell entry", got_e[0], exp_e[0]);
    got_e.delete(); got_s.delete(); got_d.delete(); got_t.delete();
    exp_e.delete(); exp_s.delete(); exp_d.delete(); exp_gap.delete(); exp_lnk.delete();

    chk(!rd_back2back, "R10", "read request spacing", 128'(rd_back2back), 128'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule